// File: doc/BRIEF.md
# Alarm-or-Watchdog Down-Counter with Reset-Cause Flag

This block holds a single down-counter paced by a slow, free-running timer clock. A one-bit role register gives the counter one of two jobs. As an alarm it raises a one-cycle alarm pulse at each expiry. As a watchdog it raises a one-cycle reset request at each expiry. The slow clock is never used as a clock. It is sampled in the system clock domain through a synchroniser and an edge detector, and each rising edge becomes one decrement tick. This works because the slow clock runs at no more than one eighth of the system clock rate.

Software uses a small register window in the system clock domain. In it, software selects the role, writes a reload value (which also restarts the count, so a write "kicks" the watchdog), reads a sticky flag that records whether a watchdog time-out happened, and reads a clock-ratio code taken from the PLL configuration. The flag survives the CPU reset. Only the external reset pin clears it, so boot code can tell a watchdog restart from a power-on or pin reset.

Top module: `lp_guard_timer`

## Requirements
- R1: The ratio register at offset 0x500 is read-only. Its bits [5:0] return 1 for `pll_cfg`=0, 2 for `pll_cfg`=1, 4 for `pll_cfg`=2 and 6 for `pll_cfg`=3 (reserved). Its upper bits read zero.
- R2: The role register at offset 0x510, bit 0, is read/write. The value 0 selects alarm and 1 selects watchdog. It reads 0 after either reset.
- R3: The counter decrements by one for each rising edge of `slow_clk`. A slow-clock high phase of any length gives exactly one tick.
- R4: The reload register at offset 0x520, bits [15:0], is read/write. Writing it loads the counter at once and restarts the countdown, and a load wins over a tick in the same cycle. A reload value of 0 holds the counter still, so no expiry occurs.
- R5: A tick that arrives while the count is 1 is an expiry. The counter takes the reload value again. In watchdog role `wdog_rst_req` pulses high for one cycle. In alarm role `alarm_pulse` pulses high for one cycle. The two pulses never occur together, and each appears on the third system clock edge after `slow_clk` rises.
- R6: The flag at offset 0x514, bit 0, is set to 1 by an expiry in watchdog role. An expiry in alarm role does not set it.
- R7: The flag is cleared only while `ext_rst_n` is low. A pulse on `cpu_rst_n` leaves it unchanged.
- R8: While `cpu_rst_n` or `ext_rst_n` is low, the role becomes alarm and the reload register and counter become RELOAD_INIT (default 0x00FF).
- R9: Reads of any other offset return zero. Writes to offsets 0x500 and 0x514 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| ext_rst_n | input | 1 | External reset pin, active low, synchronous; clears everything including the flag |
| cpu_rst_n | input | 1 | CPU reset, active low, synchronous; leaves the flag alone |
| slow_clk | input | 1 | Slow timer clock, at most one eighth of the `clk` rate |
| pll_cfg | input | 2 | PLL setting that the ratio register reports |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when no read is selected |
| alarm_pulse | output | 1 | One-cycle pulse on expiry in alarm role |
| wdog_rst_req | output | 1 | One-cycle reset request on expiry in watchdog role |

## Verification
A corrupted count shows up on the two pulse outputs: an expiry comes early, comes late, is missing, or is extra. A scoreboard holds the expected pulse for each slow-clock edge and requires it within that slow period, so such a fault is caught within one slow-clock period of its first effect. A wrong role bit or flag shows as the wrong pulse output or as a wrong flag read right after the expiry, and a flag wrongly cleared by the CPU reset shows on the first read after that reset. A synchroniser that gives two ticks for one long high phase gives an unexpected extra pulse when the reload is 1.

// File: rtl/lpg_pkg.sv
package lpg_pkg;

   localparam int ADDR_W = 12;
   localparam int DATA_W = 32;

   localparam logic [ADDR_W-1:0] OFS_RATIO  = 12'h500;
   localparam logic [ADDR_W-1:0] OFS_ROLE   = 12'h510;
   localparam logic [ADDR_W-1:0] OFS_FLAG   = 12'h514;
   localparam logic [ADDR_W-1:0] OFS_RELOAD = 12'h520;

   localparam int RATIO_W = 6;

   typedef enum logic {
      ROLE_ALARM = 1'b0,
      ROLE_WDOG  = 1'b1
   } role_e;

   // cfg 0 is the times-one bypass; other settings report twice the multiplier
   function automatic logic [RATIO_W-1:0] ratio_code(input logic [1:0] cfg);
      if (cfg == 2'd0) return RATIO_W'(1);
      return RATIO_W'({cfg, 1'b0});
   endfunction

endpackage

// File: rtl/lpg_tick_sync.sv
module lpg_tick_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic tick
);
   localparam int LAST = STAGES;

   logic [LAST:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("lpg_tick_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[LAST-1:0], async_in};
   end

   // last synchronised stage high, delayed copy still low: one rising edge
   assign tick = chain_q[LAST-1] & ~chain_q[LAST];

endmodule

// File: rtl/lpg_countdown.sv
module lpg_countdown
   import lpg_pkg::*;
#(
   parameter int              CNT_W       = 16,
   parameter logic [CNT_W-1:0] RELOAD_INIT = 16'h00FF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload_val,
   input  role_e            role,
   output logic             wd_expire,
   output logic             alarm_q,
   output logic             wdog_q
);
   logic [CNT_W-1:0] cnt_q;
   logic             expire;

   assign expire    = tick && !load && (cnt_q == CNT_W'(1));
   assign wd_expire = expire && (role == ROLE_WDOG);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= RELOAD_INIT;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (tick) begin
         if (cnt_q == CNT_W'(1))      cnt_q <= reload_val;
         else if (cnt_q != '0)        cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         alarm_q <= 1'b0;
         wdog_q  <= 1'b0;
      end else begin
         alarm_q <= expire && (role == ROLE_ALARM);
         wdog_q  <= expire && (role == ROLE_WDOG);
      end
   end

endmodule

// File: rtl/lpg_regs.sv
module lpg_regs
   import lpg_pkg::*;
#(
   parameter int              CNT_W       = 16,
   parameter logic [CNT_W-1:0] RELOAD_INIT = 16'h00FF
) (
   input  logic              clk,
   input  logic              ext_rst_n,
   input  logic              core_rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [1:0]        pll_cfg,
   input  logic              wd_expire,
   output logic [DATA_W-1:0] bus_rdata,
   output role_e             role,
   output logic              load,
   output logic [CNT_W-1:0]  load_val,
   output logic [CNT_W-1:0]  reload_val,
   output logic              flag
);
   logic             wr_en;
   role_e            role_q;
   logic [CNT_W-1:0] reload_q;
   logic             flag_q;

   assign wr_en = bus_sel && bus_wr;

   always_ff @(posedge clk) begin
      if (!core_rst_n) begin
         role_q   <= ROLE_ALARM;
         reload_q <= RELOAD_INIT;
      end else if (wr_en) begin
         if (bus_addr == OFS_ROLE)   role_q   <= role_e'(bus_wdata[0]);
         if (bus_addr == OFS_RELOAD) reload_q <= bus_wdata[CNT_W-1:0];
      end
   end

   // sticky cause flag: only the pin reset reaches it
   always_ff @(posedge clk) begin
      if (!ext_rst_n)     flag_q <= 1'b0;
      else if (wd_expire) flag_q <= 1'b1;
   end

   assign load       = wr_en && (bus_addr == OFS_RELOAD);
   assign load_val   = bus_wdata[CNT_W-1:0];
   assign reload_val = reload_q;
   assign role       = role_q;
   assign flag       = flag_q;

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         unique case (bus_addr)
            OFS_RATIO:  bus_rdata = DATA_W'(ratio_code(pll_cfg));
            OFS_ROLE:   bus_rdata = DATA_W'(role_q);
            OFS_FLAG:   bus_rdata = DATA_W'(flag_q);
            OFS_RELOAD: bus_rdata = DATA_W'(reload_q);
            default:    bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/lp_guard_timer.sv
module lp_guard_timer
   import lpg_pkg::*;
#(
   parameter int              CNT_W       = 16,
   parameter int              SYNC_STAGES = 2,
   parameter logic [CNT_W-1:0] RELOAD_INIT = 16'h00FF
) (
   input  logic              clk,
   input  logic              ext_rst_n,
   input  logic              cpu_rst_n,
   input  logic              slow_clk,
   input  logic [1:0]        pll_cfg,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              alarm_pulse,
   output logic              wdog_rst_req
);
   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_width
         $error("lp_guard_timer: CNT_W must lie in 2..DATA_W");
      end
   endgenerate

   logic             core_rst_n;
   logic             tick;
   logic             load;
   logic [CNT_W-1:0] load_val;
   logic [CNT_W-1:0] reload_val;
   logic             wd_expire;
   logic             wd_flag;
   role_e            role;

   assign core_rst_n = ext_rst_n & cpu_rst_n;

   lpg_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (core_rst_n),
      .async_in (slow_clk),
      .tick     (tick)
   );

   lpg_regs #(.CNT_W(CNT_W), .RELOAD_INIT(RELOAD_INIT)) u_regs (
      .clk        (clk),
      .ext_rst_n  (ext_rst_n),
      .core_rst_n (core_rst_n),
      .bus_sel    (bus_sel),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .pll_cfg    (pll_cfg),
      .wd_expire  (wd_expire),
      .bus_rdata  (bus_rdata),
      .role       (role),
      .load       (load),
      .load_val   (load_val),
      .reload_val (reload_val),
      .flag       (wd_flag)
   );

   lpg_countdown #(.CNT_W(CNT_W), .RELOAD_INIT(RELOAD_INIT)) u_count (
      .clk        (clk),
      .rst_n      (core_rst_n),
      .tick       (tick),
      .load       (load),
      .load_val   (load_val),
      .reload_val (reload_val),
      .role       (role),
      .wd_expire  (wd_expire),
      .alarm_q    (alarm_pulse),
      .wdog_q     (wdog_rst_req)
   );

endmodule

// File: rtl/lpg_guard_checker.sv
module lpg_guard_checker (
   input logic clk,
   input logic ext_rst_n,
   input logic cpu_rst_n,
   input logic tick,
   input logic role_bit,
   input logic wd_flag,
   input logic alarm_pulse,
   input logic wdog_rst_req
);
   assert_one_tick_R3: assert property (@(posedge clk)
      disable iff (!ext_rst_n || !cpu_rst_n) tick |=> !tick);

   assert_exclusive_R5: assert property (@(posedge clk)
      disable iff (!ext_rst_n || !cpu_rst_n) !(alarm_pulse && wdog_rst_req));

   assert_alarm_single_R5: assert property (@(posedge clk)
      disable iff (!ext_rst_n || !cpu_rst_n) alarm_pulse |=> !alarm_pulse);

   assert_wdog_single_R5: assert property (@(posedge clk)
      disable iff (!ext_rst_n || !cpu_rst_n) wdog_rst_req |=> !wdog_rst_req);

   assert_flag_on_wdog_R6: assert property (@(posedge clk)
      disable iff (!ext_rst_n) wdog_rst_req |-> wd_flag);

   assert_flag_cause_R6: assert property (@(posedge clk)
      disable iff (!ext_rst_n || !cpu_rst_n) $rose(wd_flag) |-> wdog_rst_req);

   assert_flag_sticky_R7: assert property (@(posedge clk)
      disable iff (!ext_rst_n) wd_flag |=> wd_flag);

   assert_cpu_reset_role_R8: assert property (@(posedge clk)
      disable iff (!ext_rst_n) !cpu_rst_n |=> !role_bit);

endmodule

bind lp_guard_timer lpg_guard_checker u_chk (
   .clk          (clk),
   .ext_rst_n    (ext_rst_n),
   .cpu_rst_n    (cpu_rst_n),
   .tick         (tick),
   .role_bit     (role),
   .wd_flag      (wd_flag),
   .alarm_pulse  (alarm_pulse),
   .wdog_rst_req (wdog_rst_req)
);

// File: tb/lp_guard_timer_test.sv
module lp_guard_timer_test;
   localparam int ALARM = 1;
   localparam int WDOG  = 2;

   logic        clk = 1'b0;
   logic        ext_rst_n = 1'b0;
   logic        cpu_rst_n = 1'b0;
   logic        slow_clk = 1'b0;
   logic [1:0]  pll_cfg = 2'd0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        alarm_pulse;
   logic        wdog_rst_req;

   int n_cmp = 0;
   int n_bad = 0;
   int exp_q[$];

   int m_cnt    = 255;
   int m_reload = 255;
   int m_role   = 0;
   int m_flag   = 0;

   lp_guard_timer uut (
      .clk(clk), .ext_rst_n(ext_rst_n), .cpu_rst_n(cpu_rst_n),
      .slow_clk(slow_clk), .pll_cfg(pll_cfg), .bus_sel(bus_sel),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .alarm_pulse(alarm_pulse),
      .wdog_rst_req(wdog_rst_req)
   );

   always #4 clk = ~clk;

   task automatic check(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // monitor: every pulse must match the head of the expected queue
   always @(negedge clk) begin
      if (ext_rst_n && cpu_rst_n && (alarm_pulse || wdog_rst_req)) begin
         int got;
         got = alarm_pulse ? ALARM : WDOG;
         if (alarm_pulse && wdog_rst_req) check("R5", "both pulses", 1, 0);
         if (exp_q.size() == 0) check("R5", "unexpected pulse kind", got, 0);
         else check("R5", "pulse kind", got, exp_q.pop_front());
      end
   end

   task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      if (a == 12'h510) m_role = int'(d[0]);
      if (a == 12'h520) begin m_reload = int'(d[15:0]); m_cnt = m_reload; end
   endtask

   task automatic read_check(input string req, input logic [11:0] a, input int exp);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      check(req, $sformatf("read 0x%0h", a), int'(bus_rdata), exp);
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   // one slow-clock period; the model predicts the pulse, the window checks it
   task automatic slow_edge(input int high_cycles, input string req);
      if (m_cnt == 1) begin
         exp_q.push_back(m_role ? WDOG : ALARM);
         if (m_role) m_flag = 1;
         m_cnt = m_reload;
      end else if (m_cnt > 1) begin
         m_cnt--;
      end
      @(negedge clk);
      slow_clk = 1'b1;
      repeat (high_cycles) @(negedge clk);
      slow_clk = 1'b0;
      repeat (6) @(negedge clk);
      check(req, "pending pulses after slow period", exp_q.size(), 0);
      exp_q.delete();
   endtask

   task automatic cpu_reset();
      @(negedge clk); cpu_rst_n = 1'b0;
      repeat (2) @(negedge clk); cpu_rst_n = 1'b1;
      m_role = 0; m_reload = 255; m_cnt = 255;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      ext_rst_n = 1'b1; cpu_rst_n = 1'b1;
      @(negedge clk);
      // reset state
      check("R5", "alarm_pulse after reset", int'(alarm_pulse), 0);
      check("R5", "wdog_rst_req after reset", int'(wdog_rst_req), 0);
      read_check("R2", 12'h510, 0);
      read_check("R7", 12'h514, 0);
      read_check("R8", 12'h520, 255);
      // R1 ratio codes
      for (int c = 0; c < 4; c++) begin
         pll_cfg = 2'(c);
         read_check("R1", 12'h500, (c == 0) ? 1 : 2 * c);
      end
      // R9 unmapped offsets
      read_check("R9", 12'h504, 0);
      read_check("R9", 12'h600, 0);
      // alarm role, reload 3, auto-reload over seven ticks (R3 R4 R5)
      bus_write(12'h520, 32'd3);
      read_check("R4", 12'h520, 3);
      for (int i = 0; i < 7; i++) slow_edge(5, "R5");
      read_check("R6", 12'h514, 0);
      // watchdog role with kicks (R2 R4)
      bus_write(12'h510, 32'd1);
      read_check("R2", 12'h510, 1);
      bus_write(12'h520, 32'd3);
      slow_edge(5, "R4");
      slow_edge(5, "R4");
      bus_write(12'h520, 32'd3);
      slow_edge(5, "R4");
      slow_edge(5, "R4");
      read_check("R6", 12'h514, 0);
      slow_edge(5, "R5");
      read_check("R6", 12'h514, 1);
      // R9 writes to read-only offsets
      bus_write(12'h514, 32'd0);
      read_check("R9", 12'h514, 1);
      bus_write(12'h500, 32'h3F);
      read_check("R9", 12'h500, 6);
      // R7 R8 CPU reset keeps the flag
      cpu_reset();
      read_check("R7", 12'h514, 1);
      read_check("R8", 12'h510, 0);
      read_check("R8", 12'h520, 255);
      // R4 reload zero holds
      bus_write(12'h520, 32'd0);
      for (int i = 0; i < 3; i++) slow_edge(5, "R4");
      // R3 long high phase gives one tick with reload 1
      bus_write(12'h520, 32'd1);
      slow_edge(40, "R3");
      slow_edge(40, "R3");
      // R6 watchdog with reload 1
      bus_write(12'h510, 32'd1);
      slow_edge(5, "R6");
      read_check("R6", 12'h514, 1);
      // R7 pin reset clears the flag
      @(negedge clk); ext_rst_n = 1'b0;
      repeat (2) @(negedge clk); ext_rst_n = 1'b1;
      m_role = 0; m_reload = 255; m_cnt = 255; m_flag = 0;
      read_check("R7", 12'h514, 0);
      read_check("R8", 12'h510, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule